// File: doc/BRIEF.md
# Addressed Serial Command Decoder

This block is the serial receive front end of one device in a stack of identical devices that share a chip-select, serial clock and data line. Each device has a 5-bit strapped address. A transaction opens when chip select goes low. The first eight bits, sent most significant bit first, form a command byte. That byte carries the target address, a 2-bit opcode and an even-parity bit. Depending on the opcode, the block loads a 16-bit balance word into a holding register, raises a readback or status request strobe, or raises an execute strobe that moves the holding register into the active balance control register.

A command byte with bad parity is an emergency stop. Every device that receives one clears its active control register, whatever address the byte carries. The serial inputs are brought into the system clock domain through synchronizers, and edges are detected there. The serial clock must therefore run well below the system clock.

Top module: `stack_cmd_rx`

## Requirements
- R1: After reset the holding register reads 0x000F, the active control register reads all-zero and no strobe is raised.
- R2: Command byte bits [7:3] must equal `dev_addr`. On a mismatch, every later bit of the frame is ignored: no strobe fires and no register changes until chip select has gone high and low again.
- R3: Command byte bits [2:1] select the action: 00 writes the balance word, 01 raises `readback_req`, 10 raises `status_req`, 11 raises `exec_pulse`. Each strobe lasts one clock, and no two strobes fire in the same clock.
- R4: Bit 0 gives the command byte even parity. On a parity error `abort_pulse` fires and the active control register is cleared, whether or not the address matches, and the rest of the frame is ignored.
- R5: A matching write command byte clears the holding register as soon as the byte completes. It leaves the active control register unchanged.
- R6: A write is loaded only when exactly 16 data bits arrive before chip select rises and the CRC matches. Otherwise the holding register stays cleared. Word bits [15:4] are control bits, two per cell, with cell 1 in bits [15:14] and cell 6 in bits [5:4]. Bits [3:0] are the CRC.
- R7: The CRC is a 4-bit CRC with polynomial x^4+x+1 and a zero seed, computed over word bits [15:4] most significant bit first.
- R8: `exec_pulse` copies holding register bits [15:4] into the active control register.
- R9: A serial clock rising edge seen in the same system clock cycle as chip select rising counts as the last bit of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| dev_addr | input | 5 | Strapped device address |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock, data sampled on its rising edge (asynchronous) |
| sdi | input | 1 | Serial data in, most significant bit first |
| hold_word | output | 16 | Holding register contents |
| active_ctrl | output | 12 | Active balance control bits |
| exec_pulse | output | 1 | One-clock execute strobe |
| abort_pulse | output | 1 | One-clock parity-abort strobe |
| readback_req | output | 1 | One-clock readback request strobe |
| status_req | output | 1 | One-clock status read request strobe |

## Verification
Two events can land in one system clock cycle: the final serial clock rising edge of a write, and chip select rising. The bench provokes this by driving both lines high at the same instant, so the synchronizers deliver both edges together. It judges the result by whether the holding register takes the full 16-bit word with a valid CRC (R9). Separate frames send 15 and 17 data bits, and those must leave the register cleared. This pins down the bit count that is used when the frame closes.

// File: rtl/stack_cmd_pkg.sv
package stack_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } frame_state_e;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_RDBACK = 2'b01,
    OP_STATUS = 2'b10,
    OP_EXEC   = 2'b11
  } cmd_op_e;

endpackage

// File: rtl/stack_cmd_sync.sv
module stack_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdi_s,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_rise
);
  localparam int W = 3;
  // bit 2: cs_n (idles high), bit 1: sclk, bit 0: sdi
  localparam logic [W-1:0] IDLE_VAL = 3'b100;

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] sync_v;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= IDLE_VAL;
          else        stage_q[g] <= {cs_n, sclk, sdi};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= IDLE_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_v = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= sync_v;
  end

  always_comb begin
    sdi_s     = sync_v[0];
    sclk_rise = sync_v[1] & ~prev_q[1];
    cs_fall   = ~sync_v[2] & prev_q[2];
    cs_rise   = sync_v[2] & ~prev_q[2];
  end

endmodule

// File: rtl/stack_cmd_frame.sv
module stack_cmd_frame
  import stack_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 16,
  parameter int          CRC_W    = 4,
  parameter logic [3:0]  CRC_POLY = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  output logic              clr_hold,
  output logic              load_hold,
  output logic [DATA_W-1:0] load_word,
  output logic              exec_req,
  output logic              abort_req,
  output logic              rdback_req,
  output logic              stat_req
);
  localparam int CMD_W  = ADDR_W + 3;
  localparam int CTRL_W = DATA_W - CRC_W;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_DAT = CNT_W'(DATA_W);

  function automatic logic [CRC_W-1:0] calc_crc(input logic [CTRL_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CTRL_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY[CRC_W-1:0];
    end
    return c;
  endfunction

  frame_state_e      state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_take, cnt_eff;
  logic [DATA_W-1:0] shf_q, shf_n, shf_take, shf_eff;
  logic [CMD_W-1:0]  cmd_byte;
  logic              take;
  logic              clr_n, load_n, exec_n, abort_n, rdb_n, stat_n;
  logic [DATA_W-1:0] word_n;

  always_comb begin
    take     = sclk_rise && (state_q == ST_CMD || state_q == ST_DATA);
    shf_take = {shf_q[DATA_W-2:0], sdi_s};
    cnt_take = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    shf_eff  = take ? shf_take : shf_q;
    cnt_eff  = take ? cnt_take : cnt_q;
    cmd_byte = shf_take[CMD_W-1:0];

    state_n = state_q;
    cnt_n   = cnt_q;
    shf_n   = shf_q;
    clr_n   = 1'b0;
    load_n  = 1'b0;
    exec_n  = 1'b0;
    abort_n = 1'b0;
    rdb_n   = 1'b0;
    stat_n  = 1'b0;
    word_n  = shf_eff;

    case (state_q)
      ST_IDLE: begin
        if (cs_fall) begin
          state_n = ST_CMD;
          cnt_n   = '0;
          shf_n   = '0;
        end
      end
      ST_CMD: begin
        if (take) begin
          shf_n = shf_take;
          cnt_n = cnt_take;
          if (cnt_take == CNT_CMD) begin
            if (^cmd_byte) begin
              abort_n = 1'b1;
              state_n = ST_SKIP;
            end else if (cmd_byte[CMD_W-1 -: ADDR_W] != dev_addr) begin
              state_n = ST_SKIP;
            end else begin
              case (cmd_op_e'(cmd_byte[2:1]))
                OP_WRITE: begin
                  clr_n   = 1'b1;
                  state_n = ST_DATA;
                  cnt_n   = '0;
                  shf_n   = '0;
                end
                OP_RDBACK: begin rdb_n  = 1'b1; state_n = ST_SKIP; end
                OP_STATUS: begin stat_n = 1'b1; state_n = ST_SKIP; end
                default:   begin exec_n = 1'b1; state_n = ST_SKIP; end
              endcase
            end
          end
        end
        if (cs_rise) state_n = ST_IDLE;
      end
      ST_DATA: begin
        if (take) begin
          shf_n = shf_take;
          cnt_n = cnt_take;
        end
        if (cs_rise) begin
          state_n = ST_IDLE;
          if (cnt_eff == CNT_DAT &&
              calc_crc(shf_eff[DATA_W-1:CRC_W]) == shf_eff[CRC_W-1:0])
            load_n = 1'b1;
        end
      end
      default: begin
        if (cs_rise) state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shf_q      <= '0;
      clr_hold   <= 1'b0;
      load_hold  <= 1'b0;
      exec_req   <= 1'b0;
      abort_req  <= 1'b0;
      rdback_req <= 1'b0;
      stat_req   <= 1'b0;
      load_word  <= '0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      shf_q      <= shf_n;
      clr_hold   <= clr_n;
      load_hold  <= load_n;
      exec_req   <= exec_n;
      abort_req  <= abort_n;
      rdback_req <= rdb_n;
      stat_req   <= stat_n;
      if (load_n) load_word <= word_n;
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_hold, load_hold, exec_req, abort_req, rdback_req, stat_req}));

  // R6
  load_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_hold |-> $past(cs_rise) && $past(state_q == ST_DATA));

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |=> !clr_hold && !load_hold && !exec_req && !abort_req);

endmodule

// File: rtl/stack_cmd_regs.sv
module stack_cmd_regs #(
  parameter int                DATA_W  = 16,
  parameter int                CRC_W   = 4,
  parameter logic [DATA_W-1:0] HOLD_RV = 16'h000F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_hold,
  input  logic                     load_hold,
  input  logic [DATA_W-1:0]        load_word,
  input  logic                     exec_req,
  input  logic                     abort_req,
  output logic [DATA_W-1:0]        hold_q,
  output logic [DATA_W-CRC_W-1:0]  active_q
);
  localparam int CTRL_W = DATA_W - CRC_W;

  logic [DATA_W-1:0] hold_n;
  logic [CTRL_W-1:0] active_n;
  logic              hold_en, active_en;

  always_comb begin
    hold_en  = clr_hold | load_hold;
    hold_n   = load_hold ? load_word : '0;
    active_en = abort_req | exec_req;
    active_n  = abort_req ? '0 : hold_q[DATA_W-1:CRC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= HOLD_RV;
    else if (hold_en) hold_q <= hold_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= '0;
    else if (active_en) active_q <= active_n;
  end

  // R4
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> active_q == '0);

  // R8
  exec_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && !abort_req |=> active_q == $past(hold_q[DATA_W-1:CRC_W]));

  // R5
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |=> hold_q == '0 && $stable(active_q));

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_hold |=> hold_q == $past(load_word));

endmodule

// File: rtl/stack_cmd_rx.sv
module stack_cmd_rx #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int CRC_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       dev_addr,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic [DATA_W-1:0]       hold_word,
  output logic [DATA_W-CRC_W-1:0] active_ctrl,
  output logic                    exec_pulse,
  output logic                    abort_pulse,
  output logic                    readback_req,
  output logic                    status_req
);
  logic              sdi_s, sclk_rise, cs_fall, cs_rise;
  logic              clr_hold, load_hold;
  logic [DATA_W-1:0] load_word;

  stack_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdi_s(sdi_s), .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  stack_cmd_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CRC_W(CRC_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .sdi_s(sdi_s), .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .clr_hold(clr_hold), .load_hold(load_hold), .load_word(load_word),
    .exec_req(exec_pulse), .abort_req(abort_pulse),
    .rdback_req(readback_req), .stat_req(status_req)
  );

  stack_cmd_regs #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .clr_hold(clr_hold), .load_hold(load_hold), .load_word(load_word),
    .exec_req(exec_pulse), .abort_req(abort_pulse),
    .hold_q(hold_word), .active_q(active_ctrl)
  );

endmodule

// File: tb/stack_cmd_rx_test.sv
module stack_cmd_rx_test;
  localparam logic [4:0] MY_ADDR = 5'h13;
  localparam logic [4:0] OT_ADDR = 5'h0A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] hold_word;
  logic [11:0] active_ctrl;
  logic exec_pulse, abort_pulse, readback_req, status_req;

  int checks = 0, errors = 0;
  int n_exec = 0, n_abort = 0, n_rb = 0, n_st = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stack_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .hold_word(hold_word), .active_ctrl(active_ctrl),
    .exec_pulse(exec_pulse), .abort_pulse(abort_pulse),
    .readback_req(readback_req), .status_req(status_req)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (exec_pulse)   n_exec++;
      if (abort_pulse)  n_abort++;
      if (readback_req) n_rb++;
      if (status_req)   n_st++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input logic [11:0] d);
    logic [15:0] r;
    r = {d, 4'b0000};
    for (int i = 15; i >= 4; i--)
      if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
    return r[3:0];
  endfunction

  function automatic logic [7:0] cmd(input logic [4:0] a, input logic [1:0] op, input bit bad);
    logic p;
    p = ^{a, op};
    return {a, op, p ^ bad};
  endfunction

  // shift out the top n bits of v; merge_end raises cs_n with the last sclk edge
  task automatic xfer(input logic [31:0] v, input int n, input bit merge_end);
    @(negedge clk); cs_n = 1'b0; sclk = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = v[31 - i]; sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      if (merge_end && i == n - 1) cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic write_word(input logic [4:0] a, input logic [11:0] c, input bit crc_bad);
    logic [15:0] w;
    w = {c, ref_crc(c) ^ {3'b000, crc_bad}};
    xfer({cmd(a, 2'b00, 1'b0), w, 8'h00}, 24, 1'b0);
  endtask

  task automatic t_reset();
    check(hold_word == 16'h000F, "R1 hold", hold_word, 16'h000F);
    check(active_ctrl == 12'h000, "R1 active", active_ctrl, 0);
    check(n_exec + n_abort + n_rb + n_st == 0, "R1 strobes", n_exec + n_abort + n_rb + n_st, 0);
  endtask

  task automatic t_write_exec();
    write_word(MY_ADDR, 12'hA5C, 1'b0);
    check(hold_word == {12'hA5C, ref_crc(12'hA5C)}, "R6 R7 load", hold_word, {12'hA5C, ref_crc(12'hA5C)});
    check(active_ctrl == 12'h000, "R5 active kept", active_ctrl, 0);
    xfer({cmd(MY_ADDR, 2'b11, 1'b0), 24'h0}, 8, 1'b0);
    check(n_exec == 1, "R3 exec strobe", n_exec, 1);
    check(active_ctrl == 12'hA5C, "R8 exec copy", active_ctrl, 12'hA5C);
  endtask

  task automatic t_bad_crc();
    write_word(MY_ADDR, 12'h3F0, 1'b1);
    check(hold_word == 16'h0000, "R7 bad crc clears", hold_word, 0);
    check(active_ctrl == 12'hA5C, "R5 active continues", active_ctrl, 12'hA5C);
  endtask

  task automatic t_req();
    xfer({cmd(MY_ADDR, 2'b01, 1'b0), 24'h0}, 8, 1'b0);
    check(n_rb == 1 && n_st == 0, "R3 readback", n_rb, 1);
    xfer({cmd(MY_ADDR, 2'b10, 1'b0), 24'h0}, 8, 1'b0);
    check(n_st == 1 && n_rb == 1, "R3 status", n_st, 1);
  endtask

  task automatic t_mismatch();
    write_word(MY_ADDR, 12'h111, 1'b0);
    write_word(OT_ADDR, 12'h777, 1'b0);
    check(hold_word == {12'h111, ref_crc(12'h111)}, "R2 other addr write", hold_word, {12'h111, ref_crc(12'h111)});
    xfer({cmd(OT_ADDR, 2'b01, 1'b0), cmd(MY_ADDR, 2'b11, 1'b0), 16'h0}, 16, 1'b0);
    check(n_exec == 1 && n_rb == 1, "R2 rest ignored", n_exec, 1);
    check(active_ctrl == 12'hA5C, "R2 active unchanged", active_ctrl, 12'hA5C);
  endtask

  task automatic t_merge();
    logic [15:0] w;
    w = {12'h3C1, ref_crc(12'h3C1)};
    xfer({cmd(MY_ADDR, 2'b00, 1'b0), w, 8'h00}, 24, 1'b1);
    check(hold_word == w, "R9 merged last edge", hold_word, w);
    xfer({cmd(MY_ADDR, 2'b11, 1'b0), 24'h0}, 8, 1'b0);
    check(active_ctrl == 12'h3C1, "R8 exec second", active_ctrl, 12'h3C1);
  endtask

  task automatic t_parity();
    xfer({cmd(OT_ADDR, 2'b10, 1'b1), 24'h0}, 8, 1'b0);
    check(n_abort == 1, "R4 abort strobe", n_abort, 1);
    check(active_ctrl == 12'h000, "R4 active cleared", active_ctrl, 0);
    xfer({cmd(MY_ADDR, 2'b00, 1'b1), 12'h555, ref_crc(12'h555), 8'h00}, 24, 1'b0);
    check(n_abort == 2, "R4 abort own addr", n_abort, 2);
    check(hold_word == {12'h3C1, ref_crc(12'h3C1)}, "R4 data ignored", hold_word, {12'h3C1, ref_crc(12'h3C1)});
  endtask

  task automatic t_length();
    logic [15:0] w;
    w = {12'h6A9, ref_crc(12'h6A9)};
    xfer({cmd(MY_ADDR, 2'b00, 1'b0), w, 8'h00}, 23, 1'b0);
    check(hold_word == 16'h0000, "R6 fifteen bits", hold_word, 0);
    xfer({cmd(MY_ADDR, 2'b00, 1'b0), w, 8'h00}, 25, 1'b0);
    check(hold_word == 16'h0000, "R6 seventeen bits", hold_word, 0);
    write_word(MY_ADDR, 12'h6A9, 1'b0);
    check(hold_word == w, "R6 exact sixteen", hold_word, w);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_exec();
    t_bad_crc();
    t_req();
    t_mismatch();
    t_merge();
    t_parity();
    t_length();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule